// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block drives the four coil-enable lines of a two-phase unipolar stepping motor. Each rising edge of a slow step input moves an internal excitation position by one step. The block then decodes that position into the two coil halves of phase A and the two of phase B. Two excitation schemes are offered. Full-step mode keeps two coils on at all times. Half-step mode alternates between two coils on and one coil on, which doubles the step resolution. A direction input selects the stepping order.

The step input, scheme select, direction and output enable all come from outside the system clock domain. Each of them passes through a two-flop synchroniser, and a step is taken on the rising edge of the synchronised step signal. An active-low asynchronous reset returns the position to the home state, and the outputs stay off while reset is held. A low output enable blanks all four coils and freezes the position, so that stepping resumes from the same point once the enable returns high. The outputs feed a downstream current chopper.

Top module: `step_phase_seq`

## Requirements
- R1: The position advances exactly once for each rising edge of the synchronised step input. A step input held high, or a falling edge, causes no further advance.
- R2: With `half_mode` low and `reverse` low, successive steps give the coil patterns A+BM, A+B, AM+B, AM+BM, repeating. Here A=`coil_a_p`, AM=`coil_a_m`, B=`coil_b_p` and BM=`coil_b_m`.
- R3: With `half_mode` high and `reverse` low, the eight positions 0..7 give, in stepping order: A+BM, A, A+B, B, B+AM, AM, AM+BM, BM. The full-step states are the even positions.
- R4: With `reverse` high, each mode runs through its sequence in the opposite order.
- R5: A change of `half_mode` or `reverse` does not change the outputs until the next step edge.
- R6: A full-step edge taken from an odd (single-coil) position moves one half-step in the stepping direction, to the adjacent two-coil state.
- R7: While `rst_n` is low all four coils are off. After release, with the enable high, the outputs show position 0 (A+BM).
- R8: While `enable` is low all four coils are off and step edges are ignored. When `enable` returns high, the coils show the pattern held before.
- R9: `coil_a_p` and `coil_a_m` are never on together, and neither are `coil_b_p` and `coil_b_m`. When the outputs are enabled, one or two coils are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step request; asynchronous, acts on its rising edge |
| half_mode | input | 1 | 0 = full-step two-coil mode, 1 = half-step mode |
| reverse | input | 1 | 0 = forward order, 1 = reverse order |
| enable | input | 1 | 1 = outputs driven, 0 = outputs off and position frozen |
| coil_a_p | output | 1 | Phase A, positive half |
| coil_a_m | output | 1 | Phase A, complementary half |
| coil_b_p | output | 1 | Phase B, positive half |
| coil_b_m | output | 1 | Phase B, complementary half |

## Verification
The bench uses the default two-stage synchronisers. The full cycle is only eight positions, so the sweeps cover every position in both modes and both directions, each checked against a pattern table kept in the bench. Because the position space is so small, the bench also reaches each odd position and switches to full-step there, in both directions, to cover the remapping case. Reset in mid-sequence and blanking while step edges keep arriving are checked at the coil pins.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int POS_W   = 3;
  localparam int N_COILS = 4;

  // coil vector bit order: 0 = A+, 1 = B+, 2 = A-, 3 = B-
  typedef logic [POS_W-1:0]   pos_t;
  typedef logic [N_COILS-1:0] coil_t;

  // a coil is on for three consecutive half-step positions starting at 2*k
  function automatic coil_t coil_map(input pos_t pos);
    coil_t c;
    for (int k = 0; k < N_COILS; k++) begin
      pos_t d;
      d = pos - pos_t'(2 * k);
      c[k] = (d <= pos_t'(2));
    end
    return c;
  endfunction

  function automatic pos_t next_pos(input pos_t pos, input logic half, input logic rev);
    pos_t stride;
    if (half || pos[0]) stride = pos_t'(1);
    else                stride = pos_t'(2);
    return rev ? pos - stride : pos + stride;
  endfunction
endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/step_pos_core.sv
module step_pos_core
  import step_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_s,
  input  logic half_s,
  input  logic rev_s,
  input  logic en_s,
  output pos_t pos,
  output logic step_evt,
  output logic advance
);
  logic step_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_prev <= 1'b0;
    else        step_prev <= step_s;
  end

  assign step_evt = step_s & ~step_prev;
  assign advance  = step_evt & en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (advance) pos <= next_pos(pos, half_s, rev_s);
  end

  // R1 / R5 / R8: position only moves on an enabled step event
  p_hold_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pos));
  // R1: a step level held high yields no second event
  p_single_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> !step_evt);
  // R2: full-step edge from a two-coil state lands on a two-coil state
  p_full_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !half_s && !pos[0] |=> !pos[0]);
  // R3: half-step forward moves one position
  p_half_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance && half_s && !rev_s |=> pos == pos_t'($past(pos) + pos_t'(1)));
  // R4: half-step reverse moves one position back
  p_half_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && half_s && rev_s |=> pos == pos_t'($past(pos) - pos_t'(1)));
  // R6: full-step from an odd position goes to the adjacent even one
  p_remap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !half_s && pos[0] |=> !pos[0] &&
      (pos == pos_t'($past(pos) + pos_t'(1)) || pos == pos_t'($past(pos) - pos_t'(1))));
endmodule

// File: rtl/step_coil_out.sv
module step_coil_out
  import step_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pos_t pos,
  input  logic en_s,
  output coil_t coils
);
  coil_t raw;

  assign raw   = coil_map(pos);
  assign coils = en_s ? raw : '0;

  // R9: opposite halves of a phase never on together
  p_no_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(coils[0] && coils[2]) && !(coils[1] && coils[3]));
  // R9: one or two coils energised while enabled
  p_coil_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> ($countones(coils) >= 1 && $countones(coils) <= 2));
  // R8: blanked while enable is low
  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> coils == '0);
endmodule

// File: rtl/step_phase_seq.sv
module step_phase_seq
  import step_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic half_mode,
  input  logic reverse,
  input  logic enable,
  output logic coil_a_p,
  output logic coil_a_m,
  output logic coil_b_p,
  output logic coil_b_m
);
  localparam int N_SYNC = 4;

  logic [N_SYNC-1:0] raw_in, sync_out;
  logic step_s, half_s, rev_s, en_s;
  logic step_evt, advance;
  pos_t pos;
  coil_t coils;

  assign raw_in = {enable, reverse, half_mode, step_in};

  step_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(sync_out)
  );

  assign {en_s, rev_s, half_s, step_s} = sync_out;

  step_pos_core u_core (
    .clk(clk), .rst_n(rst_n), .step_s(step_s), .half_s(half_s),
    .rev_s(rev_s), .en_s(en_s), .pos(pos), .step_evt(step_evt), .advance(advance)
  );

  step_coil_out u_out (
    .clk(clk), .rst_n(rst_n), .pos(pos), .en_s(en_s), .coils(coils)
  );

  assign coil_a_p = coils[0];
  assign coil_b_p = coils[1];
  assign coil_a_m = coils[2];
  assign coil_b_m = coils[3];

  // R7: reset released with an empty history leaves the home pattern
  p_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_s) && pos == '0 |-> coil_a_p && coil_b_m && !coil_a_m && !coil_b_p);
endmodule

// File: tb/tb_step_phase_seq.sv
module tb_step_phase_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, half_mode = 1'b0, reverse = 1'b0, enable = 1'b1;
  logic coil_a_p, coil_a_m, coil_b_p, coil_b_m;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_pos  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  step_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .half_mode(half_mode),
    .reverse(reverse), .enable(enable), .coil_a_p(coil_a_p), .coil_a_m(coil_a_m),
    .coil_b_p(coil_b_p), .coil_b_m(coil_b_m)
  );

  // pattern as {A+, A-, B+, B-} per half-step position
  function automatic logic [3:0] pattern(input int p);
    case (p)
      0: return 4'b1001;
      1: return 4'b1000;
      2: return 4'b1010;
      3: return 4'b0010;
      4: return 4'b0110;
      5: return 4'b0100;
      6: return 4'b0101;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic int model_next(input int p, input bit half, input bit rev);
    int s;
    s = (half || (p % 2 == 1)) ? 1 : 2;
    return rev ? (p - s + 8) % 8 : (p + s) % 8;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {coil_a_p, coil_a_m, coil_b_p, coil_b_m};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: coils=%b expected=%b", req, act, exp);
    end
    n_checks++;
    if ((act[3] && act[2]) || (act[1] && act[0])) begin
      n_fail++;
      $display("FAIL R9: coils=%b expected no opposing pair", act);
    end
  endtask

  task automatic pulse_step(input int high_cyc);
    step_in = 1'b1; wait_cyc(high_cyc);
    step_in = 1'b0; wait_cyc(6);
  endtask

  task automatic step_and_check(input string req);
    pulse_step(6);
    if (enable) exp_pos = model_next(exp_pos, half_mode, reverse);
    check(req, enable ? pattern(exp_pos) : 4'b0000);
  endtask

  initial begin
    wait_cyc(3);
    check("R7 in reset", 4'b0000);
    rst_n = 1'b1; wait_cyc(6);
    exp_pos = 0;
    check("R7 home", pattern(0));

    // R2: full-step forward two turns
    for (int i = 0; i < 8; i++) step_and_check("R2 full fwd");
    // R4: full-step reverse
    reverse = 1'b1; wait_cyc(6);
    check("R5 dir change no step", pattern(exp_pos));
    for (int i = 0; i < 8; i++) step_and_check("R4 full rev");
    // R3: half-step forward sweep
    reverse = 1'b0; half_mode = 1'b1; wait_cyc(6);
    check("R5 mode change no step", pattern(exp_pos));
    for (int i = 0; i < 16; i++) step_and_check("R3 half fwd");
    reverse = 1'b1; wait_cyc(6);
    for (int i = 0; i < 8; i++) step_and_check("R4 half rev");

    // R6: from each odd position, switch to full and step both ways
    for (int d = 0; d < 2; d++) begin
      for (int o = 0; o < 4; o++) begin
        half_mode = 1'b1; reverse = 1'b0; wait_cyc(6);
        while (exp_pos % 2 == 0) step_and_check("R3 reach odd");
        half_mode = 1'b0; reverse = d[0]; wait_cyc(6);
        check("R5 mode change at odd", pattern(exp_pos));
        step_and_check("R6 remap");
        half_mode = 1'b1; reverse = 1'b0; wait_cyc(6);
        step_and_check("R3 half advance");
        step_and_check("R3 half advance");
      end
    end

    // R1: long high pulse gives a single advance
    half_mode = 1'b1; reverse = 1'b0; wait_cyc(6);
    pulse_step(40);
    exp_pos = model_next(exp_pos, 1'b1, 1'b0);
    check("R1 long pulse", pattern(exp_pos));

    // R8: blank, steps ignored, resume
    enable = 1'b0; wait_cyc(6);
    check("R8 blanked", 4'b0000);
    for (int i = 0; i < 3; i++) step_and_check("R8 steps ignored");
    enable = 1'b1; wait_cyc(6);
    check("R8 resume", pattern(exp_pos));
    step_and_check("R8 step after resume");

    // R7: reset mid-sequence
    rst_n = 1'b0; wait_cyc(2);
    check("R7 reset mid", 4'b0000);
    rst_n = 1'b1; wait_cyc(6);
    exp_pos = 0;
    check("R7 home after mid reset", pattern(0));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule